// File: doc/BRIEF.md
# Combination Lock Controller

This block guards a door with a stored combination. A user presents a code on a parallel input and pulses either an Enter strobe, to try to open the door, or a Change strobe, to start replacing the stored combination. A correct Enter opens the door, and a second Enter closes it again. A correct Change moves the controller to a prompt state. A second Change there stores whatever code is on the input as the new combination.

Wrong attempts are counted, whether they are made with Enter or with Change. When the count reaches the strike limit, the controller enters an alarm state. Only the synchronous reset can clear that state. Any correct attempt clears a pending strike. The controller is a Moore machine. Its three status flags and the active-low glyph for one seven-segment digit are decoded only from registered state. They therefore change in the cycle after the strobe that caused the change.

Top module: `combo_lock_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, the controller goes to neutral: all three flags low, glyph dash, and stored code 4'b0110. The fail count is cleared.
- R2: Enter with code_in equal to the stored code opens the door: door_open is high from the next cycle.
- R3: While open, door_open stays high until Enter arrives. Enter returns the controller to neutral. Change is ignored while open.
- R4: An Enter or Change with a wrong code_in counts as a strike. A single strike leaves the outputs neutral. With the default limit of 2, the second consecutive strike raises alarm.
- R5: Alarm is latching. Enter and Change, with any code, leave it high. Only reset clears it.
- R6: A correct Enter, and entering the prompt state, both clear a pending strike. A wrong attempt that follows one of them is treated as the first strike.
- R7: Change with a matching code raises new_code_prompt. Enter is ignored in the prompt state. A second Change writes code_in to the stored code and returns the controller to neutral.
- R8: After a code change, the new code opens the door and the old code counts as a strike.
- R9: When Enter and Change arrive in the same cycle, Enter takes priority.
- R10: seg_n is active-low with bit order {g,f,e,d,c,b,a}. The encodings are: dash 7'b0111111, 'A' (alarm) 7'b0001000, 'n' (prompt) 7'b0101011, 'O' (open) 7'b1000000.
- R11: Outputs do not change in the cycle in which a strobe is applied. They change only after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| code_in | input | CODE_W | Code presented by the user |
| enter | input | 1 | Single-cycle Enter strobe |
| change | input | 1 | Single-cycle Change strobe |
| door_open | output | 1 | Door unlocked |
| alarm | output | 1 | Latched alarm |
| new_code_prompt | output | 1 | Waiting for the new combination |
| seg_n | output | 7 | Active-low status glyph, {g,f,e,d,c,b,a} |

## Verification
The bench builds the block with its default parameters: a 4-bit code, a reset combination of 4'b0110 and a strike limit of 2. With a limit of 2, the alarm is reachable within two attempts. This brings the clearing of a single pending strike, by a correct Enter and by the prompt entry, into a few cycles of stimulus. The 4-bit width lets the bench store codes that differ from the reset code. It can then show that the old code fails and that reset restores 4'b0110.

// File: rtl/lock_pkg.sv
// Package lock_pkg: shared state encoding and glyph constants for the
// combination lock controller. Assumes a single 7-segment digit.
package lock_pkg;

    typedef enum logic [1:0] {
        ST_NEUTRAL = 2'd0,
        ST_OPEN    = 2'd1,
        ST_PROMPT  = 2'd2,
        ST_ALARM   = 2'd3
    } lock_state_e;

    localparam int SEG_W = 7;

    // Active-low glyphs, bit order {g,f,e,d,c,b,a}
    localparam logic [SEG_W-1:0] GLYPH_DASH = 7'b0111111;
    localparam logic [SEG_W-1:0] GLYPH_A    = 7'b0001000;
    localparam logic [SEG_W-1:0] GLYPH_N    = 7'b0101011;
    localparam logic [SEG_W-1:0] GLYPH_O    = 7'b1000000;

endpackage

// File: rtl/lock_code_reg.sv
// Module lock_code_reg: holds the stored combination and compares it
// with the presented code. Reset loads RESET_CODE; a write pulse loads
// the presented code. Assumes wr is a single-cycle pulse from the FSM.
module lock_code_reg #(
    parameter int                CODE_W     = 4,
    parameter logic [CODE_W-1:0] RESET_CODE = 4'b0110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_in,
    input  logic              wr,
    output logic              match
);

    logic [CODE_W-1:0] stored_q;

    // Stored combination register: reset value or overwrite on wr
    always_ff @(posedge clk) begin
        if (!rst_n)
            stored_q <= RESET_CODE;
        else if (wr)
            stored_q <= code_in;
    end

    // Equality compare against the presented code
    always_comb begin
        match = (code_in == stored_q);
    end

endmodule

// File: rtl/lock_fail_track.sv
// Module lock_fail_track: counts consecutive failed attempts. It flags
// when the next failure reaches the strike limit. Clear takes priority
// over increment. Assumes MAX_FAILS >= 1.
module lock_fail_track #(
    parameter int MAX_FAILS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic clr,
    output logic last_strike
);

    localparam int FW = (MAX_FAILS > 2) ? $clog2(MAX_FAILS) : 1;
    localparam logic [FW-1:0] LAST = FW'(MAX_FAILS - 1);

    logic [FW-1:0] cnt_q;

    // Failure counter: clear, else count up until the last strike
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (inc && !last_strike)
            cnt_q <= cnt_q + 1'b1;
    end

    // The next failure completes the limit
    always_comb begin
        last_strike = (cnt_q == LAST);
    end

endmodule

// File: rtl/lock_fsm.sv
// Module lock_fsm: Moore state register of the lock. It decides the
// transitions from the strobes, the code compare result and the strike
// flag. It issues the counter and code-write controls. Assumes the
// strobes are single-cycle; Enter wins over Change.
module lock_fsm
    import lock_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enter,
    input  logic        change,
    input  logic        match,
    input  logic        last_strike,
    output lock_state_e state_q,
    output logic        fail_inc,
    output logic        fail_clr,
    output logic        code_wr
);

    lock_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_NEUTRAL;
        else
            state_q <= state_d;
    end

    // Next-state and control decode
    always_comb begin
        state_d  = state_q;
        fail_inc = 1'b0;
        fail_clr = 1'b0;
        code_wr  = 1'b0;
        unique case (state_q)
            ST_NEUTRAL: begin
                if (enter || change) begin
                    if (match) begin
                        fail_clr = 1'b1;
                        state_d  = enter ? ST_OPEN : ST_PROMPT;
                    end else begin
                        fail_inc = 1'b1;
                        if (last_strike)
                            state_d = ST_ALARM;
                    end
                end
            end
            ST_OPEN: begin
                if (enter)
                    state_d = ST_NEUTRAL;
            end
            ST_PROMPT: begin
                if (change && !enter) begin
                    code_wr = 1'b1;
                    state_d = ST_NEUTRAL;
                end
            end
            ST_ALARM: begin
                state_d = ST_ALARM;
            end
            default: state_d = ST_NEUTRAL;
        endcase
    end

endmodule

// File: rtl/lock_glyph.sv
// Module lock_glyph: turns the registered state into an active-low
// seven-segment glyph, bit order {g,f,e,d,c,b,a}. Purely combinational.
module lock_glyph
    import lock_pkg::*;
(
    input  lock_state_e      state,
    output logic [SEG_W-1:0] seg_n
);

    // State to glyph lookup
    always_comb begin
        unique case (state)
            ST_OPEN:   seg_n = GLYPH_O;
            ST_PROMPT: seg_n = GLYPH_N;
            ST_ALARM:  seg_n = GLYPH_A;
            default:   seg_n = GLYPH_DASH;
        endcase
    end

endmodule

// File: rtl/combo_lock_ctrl.sv
// Module combo_lock_ctrl: top of the combination lock. Ties together
// the code register, the strike tracker, the FSM and the glyph decoder.
// All outputs are decoded from registered state only. Assumes enter and
// change are already debounced, edge-detected single-cycle pulses.
module combo_lock_ctrl
    import lock_pkg::*;
#(
    parameter int                CODE_W     = 4,
    parameter logic [CODE_W-1:0] RESET_CODE = 4'b0110,
    parameter int                MAX_FAILS  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_in,
    input  logic              enter,
    input  logic              change,
    output logic              door_open,
    output logic              alarm,
    output logic              new_code_prompt,
    output logic [SEG_W-1:0]  seg_n
);

    lock_state_e state;
    logic        match;
    logic        last_strike;
    logic        fail_inc;
    logic        fail_clr;
    logic        code_wr;

    lock_code_reg #(
        .CODE_W     (CODE_W),
        .RESET_CODE (RESET_CODE)
    ) u_code (
        .clk     (clk),
        .rst_n   (rst_n),
        .code_in (code_in),
        .wr      (code_wr),
        .match   (match)
    );

    lock_fail_track #(
        .MAX_FAILS (MAX_FAILS)
    ) u_fail (
        .clk         (clk),
        .rst_n       (rst_n),
        .inc         (fail_inc),
        .clr         (fail_clr),
        .last_strike (last_strike)
    );

    lock_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .enter       (enter),
        .change      (change),
        .match       (match),
        .last_strike (last_strike),
        .state_q     (state),
        .fail_inc    (fail_inc),
        .fail_clr    (fail_clr),
        .code_wr     (code_wr)
    );

    lock_glyph u_glyph (
        .state (state),
        .seg_n (seg_n)
    );

    // Moore status flags from the registered state
    always_comb begin
        door_open       = (state == ST_OPEN);
        alarm           = (state == ST_ALARM);
        new_code_prompt = (state == ST_PROMPT);
    end

endmodule

// File: rtl/lock_checker.sv
// Module lock_checker: temporal properties of combo_lock_ctrl, observed
// at its ports. Attached with the bind statement at the end of this file.
module lock_checker
    import lock_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             enter,
    input logic             change,
    input logic             door_open,
    input logic             alarm,
    input logic             new_code_prompt,
    input logic [SEG_W-1:0] seg_n
);

    // R1: a reset edge yields neutral outputs
    p_reset_neutral_r1: assert property (@(posedge clk)
        !rst_n |=> (!door_open && !alarm && !new_code_prompt && seg_n == GLYPH_DASH));

    // R3: an open door stays open without Enter
    p_open_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (door_open && !enter) |=> door_open);

    // R3: Enter while open returns to neutral
    p_open_close_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (door_open && enter) |=> (!door_open && !alarm && !new_code_prompt));

    // R5: alarm latches until reset
    p_alarm_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        alarm |=> alarm);

    // R7: Enter alone does not leave the prompt
    p_prompt_enter_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (new_code_prompt && enter) |=> new_code_prompt);

    // R10: at most one flag, and the glyph agrees with the flags
    p_flags_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({door_open, alarm, new_code_prompt}));

    p_glyph_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm -> seg_n == GLYPH_A) && (door_open -> seg_n == GLYPH_O) &&
        (new_code_prompt -> seg_n == GLYPH_N));

    // R11: outputs move only when a strobe was seen at the previous edge
    p_no_strobe_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!enter && !change) |=> $stable(seg_n));

endmodule

bind combo_lock_ctrl lock_checker u_lock_checker (
    .clk             (clk),
    .rst_n           (rst_n),
    .enter           (enter),
    .change          (change),
    .door_open       (door_open),
    .alarm           (alarm),
    .new_code_prompt (new_code_prompt),
    .seg_n           (seg_n)
);

// File: tb/tb_combo_lock_ctrl.sv
// Scoreboard bench for combo_lock_ctrl. The driver applies one cycle of
// stimulus at the falling edge and queues the expected Moore state. The
// monitor compares outputs shortly after the next rising edge.
module tb_combo_lock_ctrl;

    localparam logic [6:0] E_DASH = 7'b0111111;
    localparam logic [6:0] E_A    = 7'b0001000;
    localparam logic [6:0] E_N    = 7'b0101011;
    localparam logic [6:0] E_O    = 7'b1000000;

    localparam int X_NEU  = 0;
    localparam int X_OPEN = 1;
    localparam int X_PRM  = 2;
    localparam int X_ALM  = 3;

    typedef struct {
        int    st;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] code_in = 4'd0;
    logic       enter = 1'b0;
    logic       change = 1'b0;
    logic       door_open, alarm, new_code_prompt;
    logic [6:0] seg_n;

    int   n_tests = 0;
    int   n_fail = 0;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    combo_lock_ctrl dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .code_in         (code_in),
        .enter           (enter),
        .change          (change),
        .door_open       (door_open),
        .alarm           (alarm),
        .new_code_prompt (new_code_prompt),
        .seg_n           (seg_n)
    );

    function automatic logic [6:0] glyph_of(int st);
        case (st)
            X_OPEN:  return E_O;
            X_PRM:   return E_N;
            X_ALM:   return E_A;
            default: return E_DASH;
        endcase
    endfunction

    task automatic check_outputs(int st, string tag);
        logic [9:0] act, exp;
        act = {door_open, alarm, new_code_prompt, seg_n};
        exp = {st == X_OPEN, st == X_ALM, st == X_PRM, glyph_of(st)};
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {open,alarm,prompt,seg_n} act=%b exp=%b", tag, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus plus the expected result
    task automatic step(logic rn, logic en, logic ch, logic [3:0] code, int st, string tag);
        exp_t e;
        @(negedge clk);
        rst_n   = rn;
        enter   = en;
        change  = ch;
        code_in = code;
        e.st    = st;
        e.tag   = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compare the queued expectation after each rising edge
    always @(posedge clk) begin
        #2;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check_outputs(e.st, e.tag);
        end
    end

    bit timed_out = 1'b0;

    initial begin
        #200000;
        timed_out = 1'b1;
    end

    initial begin : stim
        fork
            begin
                // R1 reset state
                step(0, 0, 0, 4'h0, X_NEU, "R1 reset neutral");
                step(1, 0, 0, 4'h6, X_NEU, "R1 idle after reset");

                // R11: no change before the edge that samples the strobe
                @(negedge clk);
                sb_q.push_back('{X_OPEN, "R2 correct enter opens"});
                enter   = 1'b1;
                code_in = 4'h6;
                #1;
                check_outputs(X_NEU, "R11 outputs unchanged in strobe cycle");
                step(1, 0, 0, 4'h6, X_OPEN, "R3 open holds");
                step(1, 0, 1, 4'h6, X_OPEN, "R3 change ignored while open");
                step(1, 1, 0, 4'h0, X_NEU, "R3 enter closes");

                // R4 and R6: strike counting
                step(1, 1, 0, 4'h3, X_NEU, "R4 single strike stays neutral");
                step(1, 1, 0, 4'h6, X_OPEN, "R6 correct enter after strike opens");
                step(1, 1, 0, 4'h0, X_NEU, "R3 enter closes");
                step(1, 1, 0, 4'h3, X_NEU, "R6 strike count was cleared");
                step(1, 0, 1, 4'h5, X_ALM, "R4 wrong change is second strike");
                step(1, 0, 0, 4'h0, X_ALM, "R5 alarm holds");
                step(1, 1, 0, 4'h6, X_ALM, "R5 enter ignored in alarm");
                step(1, 0, 1, 4'h6, X_ALM, "R5 change ignored in alarm");
                step(0, 0, 0, 4'h0, X_NEU, "R5 reset clears alarm");

                // R7 and R8: code change
                step(1, 0, 1, 4'h6, X_PRM, "R7 correct change prompts");
                step(1, 1, 0, 4'h9, X_PRM, "R7 enter ignored in prompt");
                step(1, 0, 1, 4'h9, X_NEU, "R7 second change stores code");
                step(1, 1, 0, 4'h6, X_NEU, "R8 old code is a strike");
                step(1, 1, 0, 4'h9, X_OPEN, "R8 new code opens");
                step(1, 1, 0, 4'h0, X_NEU, "R3 enter closes");

                // R6: entering the prompt clears a pending strike
                step(1, 1, 0, 4'h1, X_NEU, "R4 strike before change");
                step(1, 0, 1, 4'h9, X_PRM, "R7 prompt again");
                step(1, 0, 1, 4'hA, X_NEU, "R7 store 4'hA");
                step(1, 1, 0, 4'h1, X_NEU, "R6 prompt cleared strike");
                step(1, 1, 0, 4'hA, X_OPEN, "R8 code 4'hA opens");
                step(1, 1, 0, 4'h0, X_NEU, "R3 enter closes");

                // R9: Enter wins when both strobes arrive together
                step(1, 1, 1, 4'hA, X_OPEN, "R9 enter priority on match");
                step(1, 1, 0, 4'h0, X_NEU, "R3 enter closes");
                step(1, 1, 1, 4'h2, X_NEU, "R9 both strobes wrong is one strike");
                step(1, 1, 0, 4'h2, X_ALM, "R4 second strike alarms");

                // R1: reset restores the default combination
                step(0, 0, 0, 4'h0, X_NEU, "R1 reset");
                step(1, 1, 0, 4'h6, X_OPEN, "R1 reset code 4'b0110 opens");
                step(1, 0, 0, 4'h0, X_OPEN, "R10 open glyph held");
                @(negedge clk);
                @(negedge clk);
            end
            begin
                wait (timed_out);
            end
        join_any
        if (timed_out) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: act=timeout exp=completion");
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule